// File: doc/BRIEF.md
# Central Persistent Request Arbiter

This block orders starvation-avoidance requests in a token-counting coherence system. A requester whose ordinary request has gone unanswered for about one memory latency sends a persistent request to this arbiter. The request names a block address and the requester. The arbiter keeps competing requests in arrival order. It grants them one at a time by broadcasting an activate that names the block and the winner to every cache and memory controller.

The winner holds the grant until it sends a deactivate. The arbiter then issues one broadcast beat that carries the deactivate for the finished requester and, in the same beat, the activate for the next queued request. A handoff therefore costs three message latencies: the deactivate, the combined broadcast, and the token transfer that follows. A deactivate that does not come from the active requester is dropped and raises an error pulse. Request intake applies backpressure when the queue is full, so no request is ever lost.

Top module: `persist_arbiter`

## Requirements
- R1: While reset is held, and in the first cycle after it is released, `bc_valid`, `bc_act_en`, `bc_deact_en` and `deact_err` are 0 and `req_ready` is 1.
- R2: `req_ready` is 0 exactly when DEPTH requests are waiting. The active grant does not count as waiting. A request presented while `req_ready` is 0 is not taken and is served later once it is accepted. A slot freed at an edge does not accept a request at that same edge.
- R3: If no grant is held and the queue holds a request, the next edge takes the oldest request, and after that edge one beat appears with `bc_act_en`=1 and `bc_deact_en`=0 naming its address and id. A request accepted at edge k by an idle, empty arbiter is activated after edge k+1.
- R4: Requests are activated in the order in which they were accepted.
- R5: While a grant is held and no matching deactivate arrives, no broadcast beat is issued. Each event produces exactly one cycle of `bc_valid`.
- R6: A deactivate whose id equals the active requester, taken at edge k, produces one beat after edge k with `bc_deact_en`=1 naming the active address and id. If a request is queued, the same beat also has `bc_act_en`=1 naming the oldest queued request, which becomes active.
- R7: If the queue is empty when a matching deactivate arrives, the beat carries only the deactivate (`bc_act_en`=0) and the arbiter becomes free. A later request is then granted as in R3.
- R8: A deactivate whose id is not the active requester, or one that arrives while no grant is held, causes no deactivate broadcast and leaves the grant unchanged. It sets `deact_err` to 1 for the one cycle after that edge.
- R9: When `bc_valid` is 1, at least one of `bc_act_en` and `bc_deact_en` is 1. When `bc_valid` is 0, both are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Persistent request present |
| req_ready | output | 1 | Queue can take a request this cycle |
| req_addr | input | ADDR_W (12) | Block address of the request |
| req_id | input | ID_W (3) | Requester number |
| deact_valid | input | 1 | Deactivate message present |
| deact_id | input | ID_W (3) | Requester sending the deactivate |
| bc_valid | output | 1 | Broadcast beat present |
| bc_act_en | output | 1 | Beat carries an activate |
| bc_act_addr | output | ADDR_W (12) | Block named by the activate |
| bc_act_id | output | ID_W (3) | Requester named by the activate |
| bc_deact_en | output | 1 | Beat carries a deactivate |
| bc_deact_addr | output | ADDR_W (12) | Block named by the deactivate |
| bc_deact_id | output | ID_W (3) | Requester named by the deactivate |
| deact_err | output | 1 | Ignored deactivate seen at the previous edge |

## Verification
The hardest situation to reach is a completely full queue while a grant is held, with one more request stalled at the input at the moment the active requester deactivates. Only in that situation does the freed slot meet a waiting request, and the handoff beat has to name the next queued entry and not the stalled one. The stimulus sweeps the number of queued requests from one up to DEPTH. At the full depth it keeps an extra request presented for several cycles before it sends the deactivate. It then drains the queue and compares every handoff beat with the arrival order it recorded. A deactivate from a queued requester that is not active is sent in each sweep step, to confirm that it is rejected without disturbing the grant.

// File: rtl/prq_pkg.sv
package prq_pkg;

    parameter int ADDR_W = 12;
    parameter int ID_W   = 3;

    typedef logic [ADDR_W-1:0] blk_addr_t;
    typedef logic [ID_W-1:0]   req_id_t;

    // One persistent request: which block, which requester
    typedef struct packed {
        blk_addr_t addr;
        req_id_t   id;
    } preq_t;

    // One broadcast beat: optional deactivate and optional activate together
    typedef struct packed {
        logic  valid;
        logic  act_en;
        preq_t act;
        logic  deact_en;
        preq_t deact;
    } bcast_t;

    typedef enum logic [0:0] {
        ST_FREE = 1'b0,
        ST_HELD = 1'b1
    } grant_state_e;

    function automatic logic same_requester(input req_id_t a, input req_id_t b);
        return a == b;
    endfunction

    function automatic int ptr_width(input int depth);
        return (depth > 1) ? $clog2(depth) : 1;
    endfunction

endpackage

// File: rtl/prq_queue.sv
module prq_queue
    import prq_pkg::*;
#(
    parameter int DEPTH = 4
) (
    input  logic  clk,
    input  logic  rst,
    input  logic  push,
    input  preq_t push_data,
    input  logic  pop,
    output preq_t head,
    output logic  empty,
    output logic  full
);
    localparam int PTR_W = ptr_width(DEPTH);
    localparam int CNT_W = $clog2(DEPTH + 1);

    preq_t              slots [DEPTH];
    logic [PTR_W-1:0]   wr_ptr;
    logic [PTR_W-1:0]   rd_ptr;
    logic [CNT_W-1:0]   fill;
    logic [DEPTH-1:0]   slot_we;
    logic               do_push;
    logic               do_pop;

    assign empty   = (fill == '0);
    assign full    = (fill == CNT_W'(DEPTH));
    assign do_push = push && !full;
    assign do_pop  = pop && !empty;
    assign head    = slots[rd_ptr];

    // one write enable per storage slot
    for (genvar s = 0; s < DEPTH; s++) begin : g_slot_we
        assign slot_we[s] = do_push && (wr_ptr == PTR_W'(s));
    end

    always_ff @(posedge clk) begin
        for (int s = 0; s < DEPTH; s++) begin
            if (slot_we[s]) begin
                slots[s] <= push_data;
            end
        end
    end

    function automatic logic [PTR_W-1:0] bump(input logic [PTR_W-1:0] p);
        return (p == PTR_W'(DEPTH - 1)) ? '0 : p + PTR_W'(1);
    endfunction

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            fill   <= '0;
        end else begin
            if (do_push) begin
                wr_ptr <= bump(wr_ptr);
            end
            if (do_pop) begin
                rd_ptr <= bump(rd_ptr);
            end
            case ({do_push, do_pop})
                2'b10:   fill <= fill + CNT_W'(1);
                2'b01:   fill <= fill - CNT_W'(1);
                default: fill <= fill;
            endcase
        end
    end

endmodule

// File: rtl/prq_deact_match.sv
module prq_deact_match
    import prq_pkg::*;
(
    input  logic    deact_valid,
    input  req_id_t deact_id,
    input  logic    held,
    input  req_id_t cur_id,
    output logic    hit,
    output logic    miss
);
    // a deactivate counts only when it comes from the requester holding the grant
    assign hit  = deact_valid && held && same_requester(deact_id, cur_id);
    assign miss = deact_valid && !hit;

endmodule

// File: rtl/prq_sequencer.sv
module prq_sequencer
    import prq_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  preq_t   head,
    input  logic    q_empty,
    input  logic    hit,
    input  logic    miss,
    output logic    pop,
    output logic    held,
    output req_id_t cur_id,
    output bcast_t  bcast,
    output logic    err
);
    grant_state_e state_q;
    grant_state_e state_d;
    preq_t        cur_q;
    preq_t        cur_d;
    bcast_t       bcast_d;
    bcast_t       bcast_q;
    logic         err_q;
    logic         start_free;
    logic         start_next;

    assign held   = (state_q == ST_HELD);
    assign cur_id = cur_q.id;

    always_comb begin
        start_free = (state_q == ST_FREE) && !q_empty;
        start_next = hit && !q_empty;
        pop        = start_free || start_next;

        state_d = state_q;
        cur_d   = cur_q;
        if (pop) begin
            state_d = ST_HELD;
            cur_d   = head;
        end else if (hit) begin
            state_d = ST_FREE;
        end

        bcast_d          = '0;
        bcast_d.valid    = pop || hit;
        bcast_d.act_en   = pop;
        bcast_d.act      = pop ? head : '0;
        bcast_d.deact_en = hit;
        bcast_d.deact    = hit ? cur_q : '0;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_FREE;
            cur_q   <= '0;
            bcast_q <= '0;
            err_q   <= 1'b0;
        end else begin
            state_q <= state_d;
            cur_q   <= cur_d;
            bcast_q <= bcast_d;
            err_q   <= miss;
        end
    end

    assign bcast = bcast_q;
    assign err   = err_q;

endmodule

// File: rtl/persist_arbiter.sv
module persist_arbiter
    import prq_pkg::*;
#(
    parameter int DEPTH = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [ID_W-1:0]   req_id,
    input  logic              deact_valid,
    input  logic [ID_W-1:0]   deact_id,
    output logic              bc_valid,
    output logic              bc_act_en,
    output logic [ADDR_W-1:0] bc_act_addr,
    output logic [ID_W-1:0]   bc_act_id,
    output logic              bc_deact_en,
    output logic [ADDR_W-1:0] bc_deact_addr,
    output logic [ID_W-1:0]   bc_deact_id,
    output logic              deact_err
);
    preq_t   in_req;
    preq_t   q_head;
    logic    q_empty;
    logic    q_full;
    logic    q_pop;
    logic    held;
    req_id_t cur_id;
    logic    hit;
    logic    miss;
    bcast_t  beat;

    assign in_req.addr = req_addr;
    assign in_req.id   = req_id;
    assign req_ready   = !q_full;

    prq_queue #(.DEPTH(DEPTH)) u_queue (
        .clk       (clk),
        .rst       (rst),
        .push      (req_valid),
        .push_data (in_req),
        .pop       (q_pop),
        .head      (q_head),
        .empty     (q_empty),
        .full      (q_full)
    );

    prq_deact_match u_match (
        .deact_valid (deact_valid),
        .deact_id    (deact_id),
        .held        (held),
        .cur_id      (cur_id),
        .hit         (hit),
        .miss        (miss)
    );

    prq_sequencer u_seq (
        .clk     (clk),
        .rst     (rst),
        .head    (q_head),
        .q_empty (q_empty),
        .hit     (hit),
        .miss    (miss),
        .pop     (q_pop),
        .held    (held),
        .cur_id  (cur_id),
        .bcast   (beat),
        .err     (deact_err)
    );

    assign bc_valid      = beat.valid;
    assign bc_act_en     = beat.act_en;
    assign bc_act_addr   = beat.act.addr;
    assign bc_act_id     = beat.act.id;
    assign bc_deact_en   = beat.deact_en;
    assign bc_deact_addr = beat.deact.addr;
    assign bc_deact_id   = beat.deact.id;

endmodule

// File: rtl/persist_arbiter_chk.sv
module persist_arbiter_chk
    import prq_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              req_ready,
    input logic              deact_valid,
    input logic [ID_W-1:0]   deact_id,
    input logic              bc_valid,
    input logic              bc_act_en,
    input logic              bc_deact_en,
    input logic [ID_W-1:0]   bc_deact_id,
    input logic              deact_err
);
    // grant status rebuilt from the broadcast stream alone
    logic seen_active;

    always_ff @(posedge clk) begin
        if (rst) begin
            seen_active <= 1'b0;
        end else if (bc_valid) begin
            seen_active <= bc_act_en;
        end
    end

    assert_quiet_after_reset_R1: assert property (@(posedge clk) disable iff (rst)
        $fell(rst) |-> (!bc_valid && !deact_err && req_ready));

    assert_ready_rises_on_pop_R2: assert property (@(posedge clk) disable iff (rst)
        $rose(req_ready) |-> (bc_valid && bc_act_en));

    assert_activate_only_when_free_R3: assert property (@(posedge clk) disable iff (rst)
        (bc_valid && bc_act_en && !bc_deact_en) |-> !seen_active);

    assert_deact_from_holder_R6: assert property (@(posedge clk) disable iff (rst)
        (bc_valid && bc_deact_en) |->
            ($past(deact_valid) && (bc_deact_id == $past(deact_id)) && seen_active));

    assert_rejected_deact_R8: assert property (@(posedge clk) disable iff (rst)
        deact_err |-> ($past(deact_valid) && !bc_deact_en));

    assert_beat_payload_R9: assert property (@(posedge clk) disable iff (rst)
        bc_valid |-> (bc_act_en || bc_deact_en));

    assert_idle_payload_R9: assert property (@(posedge clk) disable iff (rst)
        !bc_valid |-> (!bc_act_en && !bc_deact_en));

endmodule

bind persist_arbiter persist_arbiter_chk u_chk (
    .clk         (clk),
    .rst         (rst),
    .req_ready   (req_ready),
    .deact_valid (deact_valid),
    .deact_id    (deact_id),
    .bc_valid    (bc_valid),
    .bc_act_en   (bc_act_en),
    .bc_deact_en (bc_deact_en),
    .bc_deact_id (bc_deact_id),
    .deact_err   (deact_err)
);

// File: tb/persist_arbiter_bench.sv
module persist_arbiter_bench;
    import prq_pkg::*;

    localparam int CLK_PERIOD = 10;
    localparam int DEPTH      = 4;
    localparam int MAXN       = DEPTH + 2;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              req_valid = 1'b0;
    logic              req_ready;
    logic [ADDR_W-1:0] req_addr = '0;
    logic [ID_W-1:0]   req_id = '0;
    logic              deact_valid = 1'b0;
    logic [ID_W-1:0]   deact_id = '0;
    logic              bc_valid;
    logic              bc_act_en;
    logic [ADDR_W-1:0] bc_act_addr;
    logic [ID_W-1:0]   bc_act_id;
    logic              bc_deact_en;
    logic [ADDR_W-1:0] bc_deact_addr;
    logic [ID_W-1:0]   bc_deact_id;
    logic              deact_err;

    int n_checks = 0;
    int n_errs   = 0;

    // broadcast log filled at negative edges
    int              nlog = 0;
    logic [ID_W-1:0] log_act_id   [0:15];
    logic [ADDR_W-1:0] log_act_addr [0:15];
    logic            log_deact_en [0:15];

    logic [ID_W-1:0]   e_id   [0:MAXN-1];
    logic [ADDR_W-1:0] e_addr [0:MAXN-1];

    persist_arbiter #(.DEPTH(DEPTH)) u_persist_arbiter (
        .clk, .rst, .req_valid, .req_ready, .req_addr, .req_id,
        .deact_valid, .deact_id, .bc_valid, .bc_act_en, .bc_act_addr,
        .bc_act_id, .bc_deact_en, .bc_deact_addr, .bc_deact_id, .deact_err
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    always @(negedge clk) begin
        if (!rst && bc_valid) begin
            if (nlog < 16) begin
                log_act_id[nlog]   = bc_act_id;
                log_act_addr[nlog] = bc_act_addr;
                log_deact_en[nlog] = bc_deact_en;
            end
            nlog = nlog + 1;
        end
    end

    task automatic chk_eq(input string req, input string what,
                          input int unsigned act, input int unsigned exp);
        n_checks++;
        if (act != exp) begin
            n_errs++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic push_req(input logic [ADDR_W-1:0] a, input logic [ID_W-1:0] id);
        @(negedge clk);
        req_valid = 1'b1;
        req_addr  = a;
        req_id    = id;
        while (!req_ready) @(negedge clk);
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    // returns at the negedge right after the edge that took the deactivate
    task automatic send_deact(input logic [ID_W-1:0] id);
        @(negedge clk);
        deact_valid = 1'b1;
        deact_id    = id;
        @(negedge clk);
        deact_valid = 1'b0;
    endtask

    task automatic check_handoff(input int k, input int total);
        chk_eq("R6", "handoff bc_valid", bc_valid, 1);
        chk_eq("R6", "handoff deact_en", bc_deact_en, 1);
        chk_eq("R6", "handoff deact_id", bc_deact_id, e_id[k]);
        chk_eq("R6", "handoff deact_addr", bc_deact_addr, e_addr[k]);
        chk_eq("R7", "handoff act_en", bc_act_en, (k < total - 1) ? 1 : 0);
        if (k < total - 1) begin
            chk_eq("R4", "next act_id", bc_act_id, e_id[k+1]);
            chk_eq("R4", "next act_addr", bc_act_addr, e_addr[k+1]);
        end
        chk_eq("R8", "no error on matching deact", deact_err, 0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_errs++;
        n_checks++;
        $display("FAIL watchdog expired actual=hung expected=done");
        $display("Result: errors=%0d of %0d checks", n_errs, n_checks);
        $finish;
    end

    initial begin
        int start;
        int total;
        repeat (3) @(negedge clk);
        chk_eq("R1", "bc_valid in reset", bc_valid, 0);
        chk_eq("R1", "req_ready in reset", req_ready, 1);
        rst = 1'b0;
        @(negedge clk);
        chk_eq("R1", "bc_valid after reset", bc_valid, 0);
        chk_eq("R1", "deact_err after reset", deact_err, 0);
        chk_eq("R1", "req_ready after reset", req_ready, 1);

        // single request: activate one edge after acceptance
        push_req(12'h123, 3'd5);
        chk_eq("R3", "no beat at acceptance edge", bc_valid, 0);
        @(negedge clk);
        chk_eq("R3", "activate bc_valid", bc_valid, 1);
        chk_eq("R3", "activate act_en", bc_act_en, 1);
        chk_eq("R3", "activate deact_en", bc_deact_en, 0);
        chk_eq("R3", "activate addr", bc_act_addr, 12'h123);
        chk_eq("R3", "activate id", bc_act_id, 5);
        @(negedge clk);
        chk_eq("R5", "single-cycle beat", bc_valid, 0);
        chk_eq("R9", "enables low when idle", {bc_act_en, bc_deact_en}, 0);

        // wrong requester deactivates
        send_deact(3'd3);
        chk_eq("R8", "wrong id flags error", deact_err, 1);
        chk_eq("R8", "wrong id no beat", bc_valid, 0);
        @(negedge clk);
        chk_eq("R8", "error is one cycle", deact_err, 0);

        // correct deactivate with nothing queued
        send_deact(3'd5);
        chk_eq("R7", "deact-only beat", bc_valid, 1);
        chk_eq("R7", "deact-only deact_en", bc_deact_en, 1);
        chk_eq("R7", "deact-only act_en", bc_act_en, 0);
        chk_eq("R7", "deact-only id", bc_deact_id, 5);
        chk_eq("R7", "deact-only addr", bc_deact_addr, 12'h123);
        chk_eq("R9", "beat carries payload", bc_act_en | bc_deact_en, 1);

        // deactivate while free
        send_deact(3'd5);
        chk_eq("R8", "free deact flags error", deact_err, 1);
        chk_eq("R8", "free deact no beat", bc_valid, 0);

        // sweep queue occupancy from one request up to a full queue
        for (int n = 1; n <= DEPTH + 1; n++) begin
            for (int i = 0; i < MAXN; i++) begin
                e_id[i]   = ID_W'((i + n) % 8);
                e_addr[i] = ADDR_W'(n * 64 + i * 5 + 1);
            end
            @(negedge clk);
            nlog = 0;
            for (int i = 0; i < n; i++) push_req(e_addr[i], e_id[i]);
            @(negedge clk);
            @(negedge clk);
            chk_eq("R5", "one beat while holding", nlog, 1);
            chk_eq("R3", "first beat activate only", log_deact_en[0], 0);
            chk_eq("R4", "first activate id", log_act_id[0], e_id[0]);
            chk_eq("R4", "first activate addr", log_act_addr[0], e_addr[0]);
            chk_eq("R2", "ready vs waiting count", req_ready, (n - 1 < DEPTH) ? 1 : 0);

            if (n >= 2) begin
                send_deact(e_id[1]);
                chk_eq("R8", "queued non-holder rejected", deact_err, 1);
                chk_eq("R8", "queued non-holder no beat", bc_valid, 0);
            end

            total = n;
            start = 0;
            if (n == DEPTH + 1) begin
                total = n + 1;
                @(negedge clk);
                req_valid = 1'b1;
                req_addr  = e_addr[n];
                req_id    = e_id[n];
                repeat (3) begin
                    @(negedge clk);
                    chk_eq("R2", "full queue stalls", req_ready, 0);
                    chk_eq("R5", "no beat while stalled", bc_valid, 0);
                end
                deact_valid = 1'b1;
                deact_id    = e_id[0];
                @(negedge clk);
                deact_valid = 1'b0;
                check_handoff(0, total);
                chk_eq("R2", "slot freed after handoff", req_ready, 1);
                @(negedge clk);
                req_valid = 1'b0;
                chk_eq("R2", "stalled request taken", req_ready, 0);
                start = 1;
            end

            for (int k = start; k < total; k++) begin
                send_deact(e_id[k]);
                check_handoff(k, total);
            end
            @(negedge clk);
            chk_eq("R7", "free after drain", bc_valid, 0);
            chk_eq("R2", "ready after drain", req_ready, 1);
        end

        $display("Result: errors=%0d of %0d checks", n_errs, n_checks);
        $finish;
    end

endmodule